// File: doc/BRIEF.md
# Five-Channel Output Compare Unit with Deferred Forcing

This block sits beside a 16-bit free-running timer and drives five output lines from five compare channels. The timer is outside the block. It presents its current value on `cnt_val` and pulses `cnt_tick` for one clock in the cycle where the counter has just stepped to that value. Each channel keeps a 16-bit compare word. When a tick arrives and the counter equals that word, the channel raises its status flag and applies its pin action. Channels 2 to 5 each own one line. Channel 1 can rewrite any group of the five lines, chosen by a mask.

Software can also trigger a channel's pin action without a real match, by writing to a write-only force register. The action is held back until the next counter tick and does not raise the flag. Flagged channels whose enable bit is set request an interrupt.

The 16-bit compare words are loaded one byte at a time, high byte first. Each channel has a two-state load sequencer:
- In `WR_WAIT_HI`, a high-byte write goes to a holding byte and moves the sequencer to `WR_HI_HELD`.
- In `WR_WAIT_HI`, a low-byte write replaces only the low byte.
- In `WR_HI_HELD`, a low-byte write commits the held byte and the new low byte together and returns to `WR_WAIT_HI`.
- In `WR_HI_HELD`, a further high-byte write replaces the held byte and stays in `WR_HI_HELD`.

Each channel also has a force sequencer:
- A force write takes it from `FRC_IDLE` to `FRC_PEND`.
- A tick in `FRC_PEND` applies the forced action and returns it to `FRC_IDLE`, unless another force write arrives in that same cycle, in which case it stays in `FRC_PEND`.

Top module: `ocu_top`

## Requirements
- R1: After reset every compare word reads 0xFFFF, and the mask, data, action-control, flag and enable registers read zero. The outputs `oc_pin` and `irq` are low.
- R2: Register addresses: channel k has its high byte at address 2(k-1) and its low byte at 2(k-1)+1. A high-byte write is only held; the compared and read-back value changes when the low byte is written, and then takes both bytes. A low-byte write with no high write since the last commit changes only the low byte.
- R3: In a cycle with `cnt_tick` high and `cnt_val` equal to a channel's compare word, the channel's flag sets and its pin action is applied. The flag register is at 0xE, with bit 7 for channel 1 down to bit 3 for channel 5.
- R4: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. If a match and a clear fall in the same cycle, the flag stays set.
- R5: `irq` is high exactly when some flag is set whose enable bit is set. The enable register is at 0xF, with the same bit positions as the flag register.
- R6: The action-control register is at 0xD. Bits 7:6 serve channel 2, 5:4 channel 3, 3:2 channel 4 and 1:0 channel 5. The codes are 00 no change, 01 toggle, 10 drive low and 11 drive high. Channel 2 drives `oc_pin[3]`, channel 3 drives `oc_pin[2]`, channel 4 drives `oc_pin[1]` and channel 5 drives `oc_pin[0]`.
- R7: On a channel 1 action, each line whose mask bit is set takes the matching data bit. The mask is at 0xB and the data at 0xC, and in both registers bits 7:3 map to `oc_pin[4:0]`. When channel 1 and another channel act on the same masked line in one tick, channel 1's value is the one kept.
- R8: Writing 1 to bit 8-k of the force register at 0xA makes channel k perform its pin action at the next tick after the write, and not during the write. A forced action never sets a flag.
- R9: The force register always reads zero. Writing 0 to a force bit, or writing any value to bits 2:0, has no effect.
- R10: If a force and a real match reach the same tick on one channel, the pin action is applied once (a toggle changes the line once) and the flag sets.
- R11: `oc_pin` changes only at the end of a cycle in which `cnt_tick` is high.
- R12: The mask, data, action-control, flag and enable registers read back what they hold, and their unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | One-cycle pulse when the timer has stepped to `cnt_val` |
| cnt_val | input | 16 | Current timer value |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| oc_pin | output | 5 | Compare output lines; bit i corresponds to port line i+3 |
| irq | output | 1 | Interrupt request |

## Verification
The in-RTL properties check the following on every cycle:
- A held high byte never disturbs the compare word before its low byte arrives.
- The output lines hold still in every cycle without a tick.
- A pending force always drains at the tick that consumes it.
- A flag can only rise right after a genuine match, so a forced action can never set one.

The bench's scenarios cover the rest:
- The action encodings and the line each channel drives.
- Channel 1's mask and data and its priority on a shared line.
- The single application of a force that coincides with a match.
- A flag that is set and cleared in the same cycle staying set.
- The byte-order behaviour seen through read-back.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    localparam int NCH    = 5;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    typedef enum logic {
        WR_WAIT_HI = 1'b0,
        WR_HI_HELD = 1'b1
    } wrst_e;

    typedef enum logic {
        FRC_IDLE = 1'b0,
        FRC_PEND = 1'b1
    } frc_e;

    localparam logic [ADDR_W-1:0] A_FORCE = 4'hA;
    localparam logic [ADDR_W-1:0] A_MASK  = 4'hB;
    localparam logic [ADDR_W-1:0] A_DATA  = 4'hC;
    localparam logic [ADDR_W-1:0] A_CTL   = 4'hD;
    localparam logic [ADDR_W-1:0] A_FLAG  = 4'hE;
    localparam logic [ADDR_W-1:0] A_EN    = 4'hF;

endpackage

// File: rtl/ocu_cmp_chan.sv
module ocu_cmp_chan
    import ocu_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              hit
);

    localparam int HI_W = CNT_W - DATA_W;

    wrst_e            st_q, st_d;
    logic [HI_W-1:0]  hold_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WR_WAIT_HI;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WR_WAIT_HI: if (wr_hi) st_d = WR_HI_HELD;
            WR_HI_HELD: if (wr_lo) st_d = WR_WAIT_HI;
        endcase
    end

    // holding byte and committed compare word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '1;
            cmp_q  <= '1;
        end else begin
            if (wr_hi) hold_q <= wdata[HI_W-1:0];
            if (wr_lo) begin
                if (st_q == WR_HI_HELD) cmp_q <= {hold_q, wdata};
                else                    cmp_q <= {cmp_q[CNT_W-1:DATA_W], wdata};
            end
        end
    end

    assign hit = tick && (cnt_val == cmp_q);

    // the compare word only moves on a low-byte write
    assert_cmp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(cmp_q));

endmodule

// File: rtl/ocu_force.sv
module ocu_force
    import ocu_pkg::*;
#(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] set_i,
    output logic [N-1:0] pend_o
);

    for (genvar g = 0; g < N; g++) begin : g_chan
        frc_e st_q, st_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= FRC_IDLE;
            else        st_q <= st_d;
        end

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                FRC_IDLE: if (set_i[g]) st_d = FRC_PEND;
                FRC_PEND: if (tick && !set_i[g]) st_d = FRC_IDLE;
            endcase
        end

        assign pend_o[g] = (st_q == FRC_PEND);

        // a pending force is consumed by the tick it waits for
        assert_force_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && pend_o[g] && !set_i[g]) |=> !pend_o[g]);
    end

endmodule

// File: rtl/ocu_pins.sv
module ocu_pins
    import ocu_pkg::*;
#(
    parameter int N = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [N-1:0]     act_i,
    input  logic [2*N-3:0]   ctl_i,
    input  logic [N-1:0]     mask_i,
    input  logic [N-1:0]     data_i,
    output logic [N-1:0]     pin_o
);

    localparam int MC = N - 1;   // index of the multi-line channel

    logic [N-1:0] pin_q, pin_d;

    always_comb begin
        pin_d = pin_q;
        for (int i = 0; i < MC; i++) begin
            if (act_i[i]) begin
                unique case (act_e'(ctl_i[2*i +: 2]))
                    ACT_NONE:   ;
                    ACT_TOGGLE: pin_d[i] = ~pin_q[i];
                    ACT_CLEAR:  pin_d[i] = 1'b0;
                    ACT_SET:    pin_d[i] = 1'b1;
                endcase
            end
        end
        if (act_i[MC]) pin_d = (pin_d & ~mask_i) | (data_i & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pin_q <= '0;
        else if (tick) pin_q <= pin_d;
    end

    assign pin_o = pin_q;

    assert_pin_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pin_q));

endmodule

// File: rtl/ocu_top.sv
module ocu_top
    import ocu_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    oc_pin,
    output logic              irq
);

    localparam int CTL_W = 2 * (NCH - 1);

    logic [CNT_W-1:0] cmp_arr [NCH];
    logic [NCH-1:0]   hit, pend, act, force_set, flag_clr;
    logic [NCH-1:0]   mask_q, data_q, en_q, flag_q;
    logic [CTL_W-1:0] ctl_q;
    logic [NCH-1:0]   wfield;

    assign wfield = bus_wdata[DATA_W-1 -: NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(2 * (NCH - 1 - i));
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(2 * (NCH - 1 - i) + 1);

        ocu_cmp_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hi   (bus_wr && (bus_addr == HI_A)),
            .wr_lo   (bus_wr && (bus_addr == LO_A)),
            .wdata   (bus_wdata),
            .tick    (cnt_tick),
            .cnt_val (cnt_val),
            .cmp_q   (cmp_arr[i]),
            .hit     (hit[i])
        );

        // a flag only rises after a genuine match, never from a force
        assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> $past(hit[i]));
    end

    assign force_set = (bus_wr && bus_addr == A_FORCE) ? wfield : '0;
    assign flag_clr  = (bus_wr && bus_addr == A_FLAG)  ? wfield : '0;

    ocu_force #(.N(NCH)) u_force (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (cnt_tick),
        .set_i  (force_set),
        .pend_o (pend)
    );

    assign act = hit | (pend & {NCH{cnt_tick}});

    ocu_pins #(.N(NCH)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (cnt_tick),
        .act_i  (act),
        .ctl_i  (ctl_q),
        .mask_i (mask_q),
        .data_i (data_q),
        .pin_o  (oc_pin)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            data_q <= '0;
            en_q   <= '0;
            ctl_q  <= '0;
            flag_q <= '0;
        end else begin
            if (bus_wr && bus_addr == A_MASK) mask_q <= wfield;
            if (bus_wr && bus_addr == A_DATA) data_q <= wfield;
            if (bus_wr && bus_addr == A_EN)   en_q   <= wfield;
            if (bus_wr && bus_addr == A_CTL)  ctl_q  <= bus_wdata[CTL_W-1:0];
            flag_q <= (flag_q & ~flag_clr) | hit;
        end
    end

    assign irq = |(flag_q & en_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_FORCE: bus_rdata = '0;
            A_MASK:  bus_rdata[DATA_W-1 -: NCH] = mask_q;
            A_DATA:  bus_rdata[DATA_W-1 -: NCH] = data_q;
            A_CTL:   bus_rdata[CTL_W-1:0] = ctl_q;
            A_FLAG:  bus_rdata[DATA_W-1 -: NCH] = flag_q;
            A_EN:    bus_rdata[DATA_W-1 -: NCH] = en_q;
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (bus_addr == ADDR_W'(2 * (NCH - 1 - i)))
                        bus_rdata = cmp_arr[i][CNT_W-1:DATA_W];
                    else if (bus_addr == ADDR_W'(2 * (NCH - 1 - i) + 1))
                        bus_rdata = cmp_arr[i][DATA_W-1:0];
                end
            end
        endcase
    end

endmodule

// File: tb/ocu_top_bench.sv
module ocu_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [4:0]  oc_pin;
    logic        irq;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    // model state; vector bit i stands for channel 5-i
    logic [15:0] m_cmp [5];
    logic [7:0]  m_hold [5];
    bit          m_held [5];
    logic [4:0]  m_pins, m_flag, m_en, m_mask, m_data, m_pend;
    logic [7:0]  m_ctl;

    ocu_top u_ocu_top (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .oc_pin(oc_pin), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // expected pins from R6 / R7
    function automatic logic [4:0] exp_pins(input logic [4:0] p, input logic [4:0] a,
                                            input logic [7:0] c, input logic [4:0] mk,
                                            input logic [4:0] dt);
        logic [4:0] r = p;
        for (int i = 0; i < 4; i++) begin
            if (a[i]) begin
                case (c[2*i +: 2])
                    2'b01: r[i] = ~p[i];
                    2'b10: r[i] = 1'b0;
                    2'b11: r[i] = 1'b1;
                    default: ;
                endcase
            end
        end
        if (a[4]) r = (r & ~mk) | (dt & mk);
        return r;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        if (a < 4'hA) begin
            int i = 4 - int'(a) / 2;
            return a[0] ? m_cmp[i][7:0] : m_cmp[i][15:8];
        end
        case (a)
            4'hB: return {m_mask, 3'b000};
            4'hC: return {m_data, 3'b000};
            4'hD: return m_ctl;
            4'hE: return {m_flag, 3'b000};
            4'hF: return {m_en, 3'b000};
            default: return 8'h00;
        endcase
    endfunction

    task automatic rd_chk(input logic [3:0] a, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_rd(a), $sformatf("read addr %0h", a));
    endtask

    // one clock: optional write, optional tick; model updated from the requirements
    task automatic cycle(input bit wr, input logic [3:0] a, input logic [7:0] d,
                         input bit tk, input logic [15:0] v);
        logic [4:0] hit = '0;
        logic [4:0] act;
        logic [4:0] npins, nflag, npend;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; cnt_tick = tk; cnt_val = v;
        if (tk) for (int i = 0; i < 5; i++) hit[i] = (v == m_cmp[i]);
        act   = tk ? (hit | m_pend) : 5'b0;
        npins = tk ? exp_pins(m_pins, act, m_ctl, m_mask, m_data) : m_pins;
        nflag = m_flag;
        npend = tk ? 5'b0 : m_pend;
        if (wr) begin
            if (a < 4'hA) begin
                int i = 4 - int'(a) / 2;
                if (!a[0]) begin m_hold[i] = d; m_held[i] = 1'b1; end
                else begin
                    m_cmp[i] = m_held[i] ? {m_hold[i], d} : {m_cmp[i][15:8], d};
                    m_held[i] = 1'b0;
                end
            end else begin
                case (a)
                    4'hA: npend = npend | d[7:3];
                    4'hB: m_mask = d[7:3];
                    4'hC: m_data = d[7:3];
                    4'hD: m_ctl = d;
                    4'hE: nflag = nflag & ~d[7:3];
                    default: m_en = d[7:3];
                endcase
            end
        end
        nflag = nflag | hit;
        @(negedge clk);
        bus_wr = 1'b0; cnt_tick = 1'b0;
        m_pins = npins; m_flag = nflag; m_pend = npend;
        chk(cur_tag, oc_pin, m_pins, "oc_pin");
        chk("R5", irq, |(m_flag & m_en), "irq");
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cycle(1'b1, a, d, 1'b0, 16'h0);
    endtask

    task automatic tk(input logic [15:0] v);
        cycle(1'b0, 4'h0, 8'h0, 1'b1, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 5; i++) begin
            m_cmp[i] = 16'hFFFF; m_hold[i] = 8'hFF; m_held[i] = 1'b0;
        end
        m_pins = '0; m_flag = '0; m_en = '0; m_mask = '0; m_data = '0; m_pend = '0;
        m_ctl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a++) rd_chk(4'(a), "R1");
        chk("R1", oc_pin, 5'b0, "oc_pin reset");
        chk("R1", irq, 1'b0, "irq reset");

        // R2 byte order
        cur_tag = "R2";
        wr(4'h2, 8'h12);
        rd_chk(4'h2, "R2");
        chk("R2", bus_rdata, 8'hFF, "high held only");
        tk(16'h1234);
        rd_chk(4'hE, "R2");
        wr(4'h3, 8'h34);
        rd_chk(4'h2, "R2"); rd_chk(4'h3, "R2");
        tk(16'h1234);
        rd_chk(4'hE, "R3");
        chk("R3", bus_rdata, 8'h40, "ch2 flag on match");
        wr(4'h3, 8'h56);
        rd_chk(4'h2, "R2"); rd_chk(4'h3, "R2");

        // R8 deferred force, no flag
        cur_tag = "R8";
        wr(4'hD, 8'h30);
        wr(4'hA, 8'h20);
        chk("R8", oc_pin, 5'b00000, "no action at write");
        tk(16'h0000);
        chk("R8", oc_pin, 5'b00100, "action at next tick");
        rd_chk(4'hE, "R8");
        chk("R8", bus_rdata, 8'h40, "force sets no flag");

        // R9 force reads zero, low bits and zeros ignored
        cur_tag = "R9";
        wr(4'hA, 8'h07);
        rd_chk(4'hA, "R9");
        tk(16'h0001);
        wr(4'hA, 8'h00);
        tk(16'h0002);

        // R10 force and match on the same tick, ch4 toggle
        cur_tag = "R10";
        wr(4'hD, 8'h34);
        wr(4'h6, 8'h01); wr(4'h7, 8'h00);
        wr(4'hA, 8'h10);
        tk(16'h0100);
        chk("R10", oc_pin, 5'b00110, "single toggle");
        rd_chk(4'hE, "R10");

        // R4 set wins over clear, then clear
        cur_tag = "R4";
        wr(4'hE, 8'h00);
        rd_chk(4'hE, "R4");
        cycle(1'b1, 4'hE, 8'h10, 1'b1, 16'h0100);
        rd_chk(4'hE, "R4");
        wr(4'hE, 8'h10);
        rd_chk(4'hE, "R4");

        // R5 enable
        wr(4'hF, 8'h40);
        chk("R5", irq, 1'b1, "ch2 flag enabled");
        wr(4'hE, 8'h40);
        chk("R5", irq, 1'b0, "flag cleared");

        // R7 ch1 mask/data and priority over ch2 on a shared line
        cur_tag = "R7";
        wr(4'hB, 8'h48); wr(4'hC, 8'h08); wr(4'hD, 8'hF4);
        wr(4'h0, 8'h02); wr(4'h1, 8'h00);
        wr(4'h2, 8'h02); wr(4'h3, 8'h00);
        tk(16'h0200);
        chk("R7", oc_pin[3], 1'b0, "ch1 wins shared line");
        chk("R7", oc_pin[0], 1'b1, "masked data bit");
        for (int a = 11; a < 16; a++) rd_chk(4'(a), "R12");

        // R11 pins hold without a tick
        cur_tag = "R11";
        wr(4'hA, 8'hF8);
        wr(4'hD, 8'h55);
        tk(16'h7777);

        // random mix, checked against the model (R3, R6, R12)
        for (int n = 0; n < 1500; n++) begin
            int op = $urandom % 8;
            logic [3:0] a = 4'($urandom);
            logic [7:0] d = 8'($urandom);
            logic [15:0] v = ($urandom % 2) ? m_cmp[$urandom % 5] : 16'($urandom % 64);
            cur_tag = "R6";
            if (op < 3)       cycle(1'b1, a, d, 1'b0, v);
            else if (op < 6)  cycle(1'b0, 4'h0, 8'h0, 1'b1, v);
            else if (op == 6) cycle(1'b1, a, d, 1'b1, v);
            else              cycle(1'b0, 4'h0, 8'h0, 1'b0, v);
            rd_chk(4'($urandom), "R12");
            rd_chk(4'hE, "R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule